// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds and advances it on its reference clock. A 32-bit fractional accumulator is increased by a programmable 32-bit addend on every enabled cycle. The time value moves forward by a programmable step, in nanoseconds, only on the cycles where that addition carries out of 32 bits. Software trims the clock frequency by adjusting the addend, so it can correct drift in steps much finer than one whole increment per cycle. A bypass mode turns compensation off, and the time then moves forward by the step on every cycle.

Software reaches the block through a simple word-addressed register port with a combinational read path. The port exposes a control word, the addend, the accumulator and the time value as a low word and a high word. Software reads the low word before the high word. The low read captures the high half at that moment, so the pair always describes one instant. Software also writes the low word before the high word. The low word waits in a staging register, and the whole 64-bit value loads in one cycle when the high word is written.

Top module: `ns_time_core`

## Requirements
- R1: After reset, reads of the control word (address 0), addend (1), accumulator (2), time low (3) and time high (4) all return zero.
- R2: While the control enable bit (bit 2) is 0, the time value and the accumulator keep their values.
- R3: With enable set and the bypass bit (bit 3) set, the time value grows by the step field (control bits 25:16) on every cycle and the accumulator holds.
- R4: With enable set and bypass clear, each cycle the accumulator becomes (accumulator + addend) mod 2^32, and the time value grows by the step exactly on the cycles where that sum reaches 2^32.
- R5: An addend write while the counter runs is used from the next cycle on, and it does not reset the accumulator.
- R6: A read of time low (3) captures bits 63:32 of the time value in the same cycle. A later read of time high (4) returns that captured value even if the live value has changed since.
- R7: A write to time low (3) leaves the time value unchanged. A following write to time high (4) loads {high data, staged low data} as one 64-bit value, and this load takes priority over a step in the same cycle.
- R8: A control write with bit 5 set clears the time value and the accumulator. Bit 5 always reads back as 0, while the enable, bypass and step fields take the written values.
- R9: The control word reads back the step in bits 25:16, bypass in bit 3 and enable in bit 2, with all other bits 0. Addresses 5 to 7 read as zero, and writes to them change no register.
- R10: A write to the accumulator (2) loads the written value, and this load takes priority over that cycle's accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle reg_rd is high, zero otherwise |

## Verification
The assertions assume that a read and a write never happen in the same cycle, and that the inputs are stable around each rising edge once the internal reset has been released. The random stimulus picks one operation per cycle, which is an idle cycle, a single read or a single write. It drives that operation on the falling edge and starts only after the synchronised reset has cleared. Soft resets, bypass toggles and loads of the accumulator and the time value are mixed in at low rates. This lets long stretches of compensated counting run between them.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned TIME_W      = 2 * DATA_W;
  localparam int unsigned STEP_W      = 10;
  localparam int unsigned CTL_EN_BIT  = 2;
  localparam int unsigned CTL_BYP_BIT = 3;
  localparam int unsigned CTL_CLR_BIT = 5;
  localparam int unsigned CTL_STEP_LSB = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ADDEND = 3'd1;
  localparam logic [ADDR_W-1:0] A_ACCUM  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TLO    = 3'd3;
  localparam logic [ADDR_W-1:0] A_THI    = 3'd4;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic              bypass;
    logic              enable;
  } ctl_t;
endpackage

// File: rtl/ntc_drift_acc.sv
module ntc_drift_acc
  import ntc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         bypass,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc,
  output logic         step
);
  logic [W:0]   sum;
  logic [W-1:0] acc_nxt;
  logic         acc_ce;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, addend};
    step    = enable & (bypass | sum[W]);
    acc_ce  = clr | ld | (enable & ~bypass);
    acc_nxt = acc;
    if (clr)                    acc_nxt = '0;
    else if (ld)                acc_nxt = ld_val;
    else if (enable && !bypass) acc_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_ce) acc <= acc_nxt;
  end

  AST_BYPASS_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bypass && !clr && !ld) |=> $stable(acc)); // R3
  AST_CARRY_MEANS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bypass && !clr && !ld) |=> ((acc < $past(acc)) == $past(step))); // R4
  AST_OFF_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clr && !ld) |=> $stable(acc)); // R2
endmodule

// File: rtl/ntc_time_reg.sv
module ntc_time_reg
  import ntc_pkg::*;
#(
  parameter int unsigned TW = TIME_W,
  parameter int unsigned SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          step,
  input  logic [SW-1:0] step_ns,
  output logic [TW-1:0] cnt
);
  logic [TW-1:0] cnt_nxt;
  logic          cnt_ce;

  always_comb begin
    cnt_ce  = clr | load | step;
    cnt_nxt = cnt;
    if (clr)       cnt_nxt = '0;
    else if (load) cnt_nxt = load_val;
    else if (step) cnt_nxt = cnt + TW'(step_ns);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_nxt;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load && !clr) |=> $stable(cnt)); // R2
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clr) |=> ((cnt - $past(cnt)) == TW'($past(step_ns)))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R8
endmodule

// File: rtl/ntc_regif.sv
module ntc_regif
  import ntc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [TIME_W-1:0] cnt_i,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] addend_o,
  output logic              clr_o,
  output logic              acc_ld_o,
  output logic              cnt_ld_o,
  output logic [TIME_W-1:0] cnt_ld_val_o
);
  logic [DATA_W-1:0] stage_lo, shadow_hi;
  logic wr_ctl, wr_add, wr_lo, wr_hi, rd_lo;
  ctl_t ctl_nxt;

  always_comb begin
    wr_ctl  = reg_wr && (reg_addr == A_CTRL);
    wr_add  = reg_wr && (reg_addr == A_ADDEND);
    wr_lo   = reg_wr && (reg_addr == A_TLO);
    wr_hi   = reg_wr && (reg_addr == A_THI);
    rd_lo   = reg_rd && (reg_addr == A_TLO);
    ctl_nxt.step   = reg_wdata[CTL_STEP_LSB +: STEP_W];
    ctl_nxt.bypass = reg_wdata[CTL_BYP_BIT];
    ctl_nxt.enable = reg_wdata[CTL_EN_BIT];
    clr_o        = wr_ctl && reg_wdata[CTL_CLR_BIT];
    acc_ld_o     = reg_wr && (reg_addr == A_ACCUM);
    cnt_ld_o     = wr_hi;
    cnt_ld_val_o = {reg_wdata, stage_lo};
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[DATA_W-1:CTL_STEP_LSB+STEP_W],
                          reg_wdata[CTL_STEP_LSB-1:CTL_CLR_BIT+1],
                          reg_wdata[CTL_CLR_BIT-1:CTL_BYP_BIT+1],
                          reg_wdata[CTL_EN_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o     <= '0;
      addend_o  <= '0;
      stage_lo  <= '0;
      shadow_hi <= '0;
    end else begin
      if (wr_ctl) ctl_o     <= ctl_nxt;
      if (wr_add) addend_o  <= reg_wdata;
      if (wr_lo)  stage_lo  <= reg_wdata;
      if (rd_lo)  shadow_hi <= cnt_i[TIME_W-1:DATA_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[CTL_STEP_LSB +: STEP_W] = ctl_o.step;
          reg_rdata[CTL_BYP_BIT]            = ctl_o.bypass;
          reg_rdata[CTL_EN_BIT]             = ctl_o.enable;
        end
        A_ADDEND: reg_rdata = addend_o;
        A_ACCUM:  reg_rdata = acc_i;
        A_TLO:    reg_rdata = cnt_i[DATA_W-1:0];
        A_THI:    reg_rdata = shadow_hi;
        default:  reg_rdata = '0;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R9
  AST_HI_READS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TLO) |=> (!reg_rd || reg_addr != A_THI ||
      reg_rdata == $past(cnt_i[TIME_W-1:DATA_W]))); // R6
endmodule

// File: rtl/ns_time_core.sv
module ns_time_core
  import ntc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic rst_meta, rst_sync_n;
  ctl_t ctl;
  logic [DATA_W-1:0] addend, acc;
  logic [TIME_W-1:0] cnt, cnt_ld_val;
  logic clr, acc_ld, cnt_ld, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ntc_regif u_regif (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_i(acc), .cnt_i(cnt),
    .ctl_o(ctl), .addend_o(addend), .clr_o(clr),
    .acc_ld_o(acc_ld), .cnt_ld_o(cnt_ld), .cnt_ld_val_o(cnt_ld_val)
  );

  ntc_drift_acc #(.W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n),
    .enable(ctl.enable), .bypass(ctl.bypass), .clr(clr),
    .ld(acc_ld), .ld_val(reg_wdata), .addend(addend),
    .acc(acc), .step(step)
  );

  ntc_time_reg #(.TW(TIME_W), .SW(STEP_W)) u_time (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(clr), .load(cnt_ld), .load_val(cnt_ld_val),
    .step(step), .step_ns(ctl.step), .cnt(cnt)
  );

  AST_LO_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == A_TLO && !step) |=> $stable(cnt)); // R7
  AST_HI_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == A_THI) |=> (cnt[TIME_W-1:DATA_W] == $past(reg_wdata))); // R7
  AST_CLR_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTL_CLR_BIT]) |=> (acc == '0)); // R8
endmodule

// File: tb/ns_time_core_tb_top.sv
module ns_time_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0, n_errs = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_cnt;
  logic [31:0] m_acc, m_add, m_stage, m_shadow;
  logic [9:0]  m_step;
  logic        m_en, m_byp;

  always #2.5 clk = ~clk;

  ns_time_core dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {6'd0, m_step, 12'd0, m_byp, m_en, 2'd0};
      3'd1: return m_add;
      3'd2: return m_acc;
      3'd3: return m_cnt[31:0];
      3'd4: return m_shadow;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R9/R8 ctrl";
      3'd1: return "R5 addend";
      3'd2: return "R4/R10 accum";
      3'd3: return "R4/R7 time lo";
      3'd4: return "R6 time hi";
      default: return "R9 unused addr";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] d);
    logic [32:0] s;
    logic stp;
    logic [31:0] nacc;
    if (rd && a == 3'd3) m_shadow = m_cnt[63:32];
    if (wr && a == 3'd0 && d[5]) begin
      m_cnt = '0; m_acc = '0;
    end else begin
      stp = 0; nacc = m_acc;
      if (m_en) begin
        if (m_byp) stp = 1;
        else begin s = {1'b0, m_acc} + {1'b0, m_add}; stp = s[32]; nacc = s[31:0]; end
      end
      if (wr && a == 3'd2) nacc = d;
      if (wr && a == 3'd4) m_cnt = {d, m_stage};
      else if (stp) m_cnt = m_cnt + 64'(m_step);
      m_acc = nacc;
    end
    if (wr && a == 3'd0) begin m_step = d[25:16]; m_byp = d[3]; m_en = d[2]; end
    if (wr && a == 3'd1) m_add = d;
    if (wr && a == 3'd3) m_stage = d;
  endtask

  // one bus cycle; a read is checked against the model before the edge
  task automatic op(input bit wr, input bit rd, input logic [2:0] a,
                    input logic [31:0] d, input string req);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    if (rd) check(req, reg_rdata, exp_read(a));
    @(posedge clk);
    model_edge(wr, rd, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 3'd0, 32'd0, "");
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) op(0, 1, 3'(a), 32'd0, tag);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1588;
    void'($urandom(seed));
    m_cnt = '0; m_acc = '0; m_add = '0; m_stage = '0; m_shadow = '0;
    m_step = '0; m_en = 0; m_byp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd_all("R1 reset state");

    // R9: field placement and unused addresses
    op(1, 0, 3'd0, 32'hFFFF_FFD3, "");        // enable clear, step=0x3FF
    op(0, 1, 3'd0, 0, "R9 ctrl fields");
    op(1, 0, 3'd6, 32'hDEAD_BEEF, "");
    rd_all("R9 no effect of unused write");

    // R7: staged low write does not disturb the time value
    op(1, 0, 3'd3, 32'hFFFF_FFF8, "");
    op(0, 1, 3'd3, 0, "R7 lo write staged only");
    op(1, 0, 3'd4, 32'h0000_0005, "");
    op(0, 1, 3'd3, 0, "R7 atomic load lo");
    op(0, 1, 3'd4, 0, "R7 atomic load hi");
    idle(4);
    op(0, 1, 3'd3, 0, "R2 held while disabled");

    // R3 and R6: bypass run across the low-word wrap
    op(1, 0, 3'd1, 32'h1234_5678, "");
    op(1, 0, 3'd0, (32'd10 << 16) | 32'h0C, "");
    op(0, 1, 3'd3, 0, "R3 bypass step");
    idle(3);
    op(0, 1, 3'd4, 0, "R6 hi returns shadow");
    op(0, 1, 3'd2, 0, "R3 accumulator held");
    check("R6 live hi moved past shadow", m_cnt[63:32], 32'd6);

    // R4: compensated counting, carry every fourth cycle
    op(1, 0, 3'd0, (32'd8 << 16) | 32'h24, "");   // clear + enable
    op(1, 0, 3'd1, 32'h4000_0000, "");
    idle(8);
    op(0, 1, 3'd3, 0, "R4 carry-gated step");
    op(0, 1, 3'd2, 0, "R4 wrapped accumulator");

    // R5: addend change mid-run keeps accumulator
    op(1, 0, 3'd1, 32'h8000_0001, "");
    op(0, 1, 3'd2, 0, "R5 accumulator kept");
    idle(3);
    op(0, 1, 3'd3, 0, "R5 new addend used");

    // R10: accumulator load beats accumulation
    op(1, 0, 3'd2, 32'hFFFF_FFFF, "");
    op(0, 1, 3'd2, 0, "R10 accumulator load");
    op(0, 1, 3'd3, 0, "R10 carry after load");

    // R8: soft reset
    op(1, 0, 3'd0, (32'd3 << 16) | 32'h2C, "");
    op(0, 1, 3'd0, 0, "R8 clear bit reads zero");
    op(0, 1, 3'd3, 0, "R8 time cleared");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int unsigned k;
      logic [2:0] a;
      logic [31:0] d;
      k = $urandom_range(0, 99);
      a = 3'($urandom_range(0, 7));
      d = $urandom;
      if (k < 40) op(0, 0, 3'd0, 0, "");
      else if (k < 75) op(0, 1, a, 0, req_of(a));
      else begin
        if (a == 3'd0) begin
          d[5] = ($urandom_range(0, 9) == 0);
          d[2] = ($urandom_range(0, 4) != 0);
          d[3] = ($urandom_range(0, 3) == 0);
        end
        op(1, 0, a, d, "");
      end
    end
    rd_all("R4 final state");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule